// File: doc/BRIEF.md
# Unaligned Word Load/Store Merge Unit

This unit carries out the four partial-word access operations that a processor uses to move a 32-bit word across a word boundary: load-high-part, load-low-part, store-high-part and store-low-part. Each command supplies an operation code, a base address, a 16-bit signed displacement, a register index and the current register value. The unit forms the effective address and reads the aligned word that contains it through a simple synchronous memory port. A load merges bytes of that word into the register value and returns the result on a writeback port. A store merges register bytes into the word and writes the word back to the same aligned address. This read-then-write sequence replaces byte-enable writes.

Byte order is little-endian. The two low bits of the effective address, called the lane index n below, select how many bytes move and where they land. A software pair of a load-high and a load-low, or of a store-high and a store-low, on the two ends of an unaligned word moves the whole word.

Top module: `uwa_merge_unit`

## Requirements
- R1: The effective address is cmd_base plus cmd_offset sign-extended to 32 bits, taken modulo 2^32. Every memory access of a command uses that address with bits [1:0] cleared, and n is its bits [1:0].
- R2: Operation code 0 (load-high) returns (reg & M) | (mem << S), where M is 0x00FFFFFF, 0x0000FFFF, 0x000000FF or 0 and S is 24, 16, 8 or 0, for n = 0, 1, 2, 3.
- R3: Operation code 1 (load-low) returns (reg & M) | (mem >> S), where M is 0, 0xFF000000, 0xFFFF0000 or 0xFFFFFF00 and S is 0, 8, 16 or 24, for n = 0, 1, 2, 3.
- R4: Operation code 2 (store-high) writes (mem & M) | (reg >> S), where M is 0xFFFFFF00, 0xFFFF0000, 0xFF000000 or 0 and S is 24, 16, 8 or 0, for n = 0, 1, 2, 3.
- R5: Operation code 3 (store-low) writes (mem & M) | (reg << S), where M is 0, 0x000000FF, 0x0000FFFF or 0x00FFFFFF and S is 0, 8, 16 or 24, for n = 0, 1, 2, 3.
- R6: A load whose register index is 0 still issues its memory read, raises done, and produces no writeback.
- R7: If a command is accepted at edge k, the read request is presented in the cycle after edge k. Read data is expected in the following cycle. A load raises wb_valid and done in that same cycle. A store presents its write request together with done one cycle later. done lasts one cycle.
- R8: cmd_ready is high only while no command is in flight. A cmd_valid held high while the unit is busy is not accepted a second time.
- R9: While reset is applied, cmd_ready is 1 and mem_req, wb_valid and done are 0.
- R10: A store never raises wb_valid, and a load never raises mem_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command accepted when valid |
| cmd_op | input | 2 | 0 load-high, 1 load-low, 2 store-high, 3 store-low |
| cmd_base | input | 32 | Base address |
| cmd_offset | input | 16 | Signed displacement |
| cmd_reg_idx | input | 5 | Register index (load destination) |
| cmd_reg_val | input | 32 | Current register value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Aligned word address |
| mem_wdata | output | 32 | Merged word for a write |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| wb_valid | output | 1 | Register writeback strobe |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | 32 | Writeback value |
| done | output | 1 | Command complete pulse |

## Verification
For a load, the writeback strobe and the completion pulse fall in the same cycle, the one in which read data returns. For a store, the completion pulse shares its cycle with the write request. The scoreboard stamps every expected read, writeback and write with the exact cycle it must appear in, counted from the acceptance edge. A coincident event that slips by one cycle, or that shows up for the wrong kind of command, is therefore reported. Commands are issued back to back, some with cmd_valid held high into the busy period, so that completion of one command and the offer of the next sit next to each other.

// File: rtl/uwa_pkg.sv
package uwa_pkg;
  typedef enum logic [1:0] {
    OP_LD_HI = 2'd0,
    OP_LD_LO = 2'd1,
    OP_ST_HI = 2'd2,
    OP_ST_LO = 2'd3
  } uwa_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_MERGE = 2'd2,
    ST_WRITE = 2'd3
  } uwa_state_e;
endpackage

// File: rtl/uwa_addr_gen.sv
module uwa_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int LANE_W = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] word_addr,
  output logic [LANE_W-1:0] lane
);
  logic [ADDR_W-1:0] eff;

  always_comb begin
    eff       = base + {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
    word_addr = {eff[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    lane      = eff[LANE_W-1:0];
  end
endmodule

// File: rtl/uwa_merge.sv
module uwa_merge
  import uwa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 2
) (
  input  uwa_op_e           op,
  input  logic [LANE_W-1:0] lane,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] mem_word,
  output logic [DATA_W-1:0] merged
);
  localparam int SH_W = $clog2(DATA_W) + 1;
  localparam logic [DATA_W-1:0] ONES = '1;

  logic [SH_W-1:0] sh_lo, sh_lo_next, sh_top;
  logic [DATA_W-1:0] keep_mask;

  always_comb begin
    sh_lo      = {1'b0, lane, 3'b000};
    sh_lo_next = sh_lo + SH_W'(8);
    sh_top     = SH_W'(DATA_W - 8) - sh_lo;
    keep_mask  = '0;
    merged     = '0;
    unique case (op)
      OP_LD_HI: begin
        keep_mask = ONES >> sh_lo_next;
        merged    = (reg_val & keep_mask) | (mem_word << sh_top);
      end
      OP_LD_LO: begin
        keep_mask = ~(ONES >> sh_lo);
        merged    = (reg_val & keep_mask) | (mem_word >> sh_lo);
      end
      OP_ST_HI: begin
        keep_mask = ONES << sh_lo_next;
        merged    = (mem_word & keep_mask) | (reg_val >> sh_top);
      end
      OP_ST_LO: begin
        keep_mask = ~(ONES << sh_lo);
        merged    = (mem_word & keep_mask) | (reg_val << sh_lo);
      end
      default: merged = '0;
    endcase
  end
endmodule

// File: rtl/uwa_ctrl.sv
module uwa_ctrl
  import uwa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  uwa_op_e           cmd_op,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [DATA_W-1:0] cmd_val,
  input  logic [ADDR_W-1:0] cmd_word_addr,
  input  logic [LANE_W-1:0] cmd_lane,
  output uwa_op_e           op_q,
  output logic [LANE_W-1:0] lane_q,
  output logic [DATA_W-1:0] val_q,
  input  logic [DATA_W-1:0] merged,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data,
  output logic              done
);
  uwa_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              cap_en, wd_en, is_store;

  assign is_store = op_q[1];
  assign cap_en   = (state_q == ST_IDLE) && cmd_valid;
  assign wd_en    = (state_q == ST_MERGE) && is_store;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cmd_valid) state_d = ST_READ;
      ST_READ:  state_d = ST_MERGE;
      ST_MERGE: state_d = is_store ? ST_WRITE : ST_IDLE;
      ST_WRITE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_LD_HI;
      lane_q <= '0;
      val_q  <= '0;
      idx_q  <= '0;
      addr_q <= '0;
    end else if (cap_en) begin
      op_q   <= cmd_op;
      lane_q <= cmd_lane;
      val_q  <= cmd_val;
      idx_q  <= cmd_idx;
      addr_q <= cmd_word_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wdata_q <= '0;
    else if (wd_en) wdata_q <= merged;
  end

  always_comb begin
    cmd_ready = (state_q == ST_IDLE);
    mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
    mem_we    = (state_q == ST_WRITE);
    mem_addr  = addr_q;
    mem_wdata = wdata_q;
    wb_valid  = (state_q == ST_MERGE) && !is_store && (idx_q != '0);
    wb_idx    = idx_q;
    wb_data   = merged;
    done      = ((state_q == ST_MERGE) && !is_store) || (state_q == ST_WRITE);
  end

  // R8: an accepted command makes the unit busy and starts its read
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready && mem_req && !mem_we);
  // R7: a write comes exactly two cycles after the read of the same command
  a_r7_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> $past(mem_req && !mem_we, 2));
  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: no writeback to register 0
  a_r6_no_zero_wb: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_idx != '0);
  // R10: writeback and memory write never coincide
  a_r10_wb_excl_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !wb_valid);
endmodule

// File: rtl/uwa_merge_unit.sv
module uwa_merge_unit
  import uwa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [OFF_W-1:0]  cmd_offset,
  input  logic [IDX_W-1:0]  cmd_reg_idx,
  input  logic [DATA_W-1:0] cmd_reg_val,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data,
  output logic              done
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [ADDR_W-1:0] word_addr;
  logic [LANE_W-1:0] lane, lane_q;
  logic [DATA_W-1:0] val_q, merged;
  uwa_op_e           op_q;

  uwa_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_W(LANE_W)) u_addr (
    .base(cmd_base), .offset(cmd_offset), .word_addr(word_addr), .lane(lane)
  );

  uwa_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LANE_W(LANE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(uwa_op_e'(cmd_op)), .cmd_idx(cmd_reg_idx), .cmd_val(cmd_reg_val),
    .cmd_word_addr(word_addr), .cmd_lane(lane),
    .op_q(op_q), .lane_q(lane_q), .val_q(val_q), .merged(merged),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data), .done(done)
  );

  uwa_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_merge (
    .op(op_q), .lane(lane_q), .reg_val(val_q), .mem_word(mem_rdata), .merged(merged)
  );

  // R1: every memory access is word aligned
  a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[LANE_W-1:0] == '0);
endmodule

// File: tb/uwa_merge_unit_test.sv
module uwa_merge_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [31:0] cmd_base = '0;
  logic [15:0] cmd_offset = '0;
  logic [4:0]  cmd_reg_idx = '0;
  logic [31:0] cmd_reg_val = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        wb_valid, done;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;

  always #2 clk = ~clk;

  uwa_merge_unit uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_base(cmd_base), .cmd_offset(cmd_offset),
    .cmd_reg_idx(cmd_reg_idx), .cmd_reg_val(cmd_reg_val),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
    .done(done)
  );

  typedef struct {
    int          kind;   // 0 read, 1 writeback, 2 write
    logic [31:0] a;
    logic [31:0] d;
    int          cyc;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] bmem [16];
  logic [31:0] shadow [16];
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  bit          finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) bmem[mem_addr[5:2]] <= mem_wdata;
      else        mem_rdata <= bmem[mem_addr[5:2]];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  function automatic logic [31:0] model(input int op, input int n, input logic [31:0] r, input logic [31:0] m);
    logic [31:0] res;
    for (int k = 0; k < 4; k++) begin
      case (op)
        0: res[8*k +: 8] = (k >= 3 - n) ? m[8*(k-3+n) +: 8] : r[8*k +: 8];
        1: res[8*k +: 8] = (k <= 3 - n) ? m[8*(k+n) +: 8] : r[8*k +: 8];
        2: res[8*k +: 8] = (k <= n) ? r[8*(k+3-n) +: 8] : m[8*k +: 8];
        default: res[8*k +: 8] = (k >= n) ? r[8*(k-n) +: 8] : m[8*k +: 8];
      endcase
    end
    return res;
  endfunction

  function automatic string op_tag(input int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic pop_cmp(input int kind, input logic [31:0] a, input logic [31:0] d);
    exp_t e;
    if (exp_q.size() == 0) begin
      check(0, $sformatf("R10 unexpected event kind %0d", kind), a, 32'h0);
      return;
    end
    e = exp_q.pop_front();
    check(e.kind == kind, {e.tag, " event kind"}, 32'(kind), 32'(e.kind));
    check(e.cyc == cyc, {"R7 event cycle for ", e.tag}, 32'(cyc), 32'(e.cyc));
    check(e.a == a, {e.tag, " address/index"}, a, e.a);
    if (kind != 0) check(e.d == d, {e.tag, " data"}, d, e.d);
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (mem_req && !mem_we) pop_cmp(0, mem_addr, 32'h0);
      if (wb_valid)           pop_cmp(1, {27'h0, wb_idx}, wb_data);
      if (mem_req && mem_we)  pop_cmp(2, mem_addr, mem_wdata);
    end
  end

  task automatic issue(input int op, input logic [31:0] base, input logic [15:0] off,
                       input logic [4:0] idx, input logic [31:0] rv, input int hold);
    logic [31:0] ea, wa, mw, res;
    int n, c, w;
    exp_t e;
    ea = base + {{16{off[15]}}, off};   // R1
    wa = {ea[31:2], 2'b00};
    n  = int'(ea[1:0]);
    mw = shadow[wa[5:2]];
    res = model(op, n, rv, mw);
    cmd_op = op[1:0]; cmd_base = base; cmd_offset = off;
    cmd_reg_idx = idx; cmd_reg_val = rv; cmd_valid = 1'b1;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    c = cyc;
    e = '{0, wa, 32'h0, c + 1, "R1"}; exp_q.push_back(e);
    if (op >= 2) begin
      e = '{2, wa, res, c + 3, op_tag(op)}; exp_q.push_back(e);
      shadow[wa[5:2]] = res;
    end else if (idx != 0) begin
      e = '{1, {27'h0, idx}, res, c + 2, op_tag(op)}; exp_q.push_back(e);
    end
    @(posedge clk);
    repeat (hold) @(posedge clk);
    #1 cmd_valid = 1'b0;
    if (hold == 0) begin
      @(negedge clk);
      check(!cmd_ready, "R8 busy after accept", {31'h0, cmd_ready}, 32'h0);
    end
    w = 0;
    while (!done && w < 20) begin @(negedge clk); w++; end
    check(done && cyc == c + ((op >= 2) ? 3 : 2), op >= 2 ? "R7 store done cycle" : "R7 load done cycle",
          32'(cyc), 32'(c + ((op >= 2) ? 3 : 2)));
    if (op < 2 && idx == 0) check(!wb_valid, "R6 no writeback for index 0", {31'h0, wb_valid}, 32'h0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      bmem[i]   = 32'hA1B2C3D4 ^ (32'(i) * 32'h01030507);
      shadow[i] = bmem[i];
    end
    repeat (3) @(posedge clk);
    #1;
    check(cmd_ready == 1'b1, "R9 reset cmd_ready", {31'h0, cmd_ready}, 32'h1);
    check(mem_req == 1'b0, "R9 reset mem_req", {31'h0, mem_req}, 32'h0);
    check(wb_valid == 1'b0, "R9 reset wb_valid", {31'h0, wb_valid}, 32'h0);
    check(done == 1'b0, "R9 reset done", {31'h0, done}, 32'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R2 R3 R4 R5: every operation at every lane index
    for (int op = 0; op < 4; op++)
      for (int n = 0; n < 4; n++)
        issue(op, 32'h0000_0010, 16'(12 + n), 5'(3 + op), 32'h1122_3344 + 32'(op * 16 + n) * 32'h0101_0101, 0);

    // R1: negative displacement is sign extended
    issue(0, 32'h0000_0020, 16'hFFF5, 5'd7, 32'hDEAD_BEEF, 0);
    issue(3, 32'h0000_0020, 16'hFFEA, 5'd8, 32'hCAFE_F00D, 0);
    // R1: address wraps modulo 2^32
    issue(1, 32'hFFFF_FFFE, 16'h0003, 5'd9, 32'h5555_AAAA, 0);
    issue(2, 32'hFFFF_FFF0, 16'h0016, 5'd10, 32'h0F1E_2D3C, 0);
    // R6: destination index 0 still reads, no writeback
    issue(0, 32'h0000_0008, 16'h0001, 5'd0, 32'hFFFF_FFFF, 0);
    issue(1, 32'h0000_0008, 16'h0002, 5'd0, 32'h1234_5678, 0);
    // R8: cmd_valid held into busy period is accepted only once
    issue(2, 32'h0000_0004, 16'h0001, 5'd11, 32'h8899_AABB, 2);
    issue(1, 32'h0000_0004, 16'h0000, 5'd12, 32'h7766_5544, 1);
    // unaligned word pair: store-low then store-high, then read back with loads
    issue(3, 32'h0000_0030, 16'h0001, 5'd13, 32'h0BAD_C0DE, 0);
    issue(2, 32'h0000_0030, 16'h0004, 5'd13, 32'h0BAD_C0DE, 0);
    issue(1, 32'h0000_0030, 16'h0001, 5'd14, 32'h0, 0);
    issue(0, 32'h0000_0030, 16'h0004, 5'd14, 32'h0, 0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 all expected events seen", 32'(exp_q.size()), 32'h0);
    for (int i = 0; i < 16; i++)
      check(bmem[i] === shadow[i], $sformatf("R4 R5 memory word %0d", i), bmem[i], shadow[i]);
    finish_run();
  end
endmodule